// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects four live condition flags from a clock-generator control plane: initialization in progress, loss of lock on PLL A, loss of lock on PLL B, and loss of the input reference. They are assumed to arrive already synchronous to `clk`. Each flag is shown live in a read-only status register. Each rising flag is also caught in a sticky register, which software clears by writing zero to the bit. A per-source mask register decides which sticky bits may pull the active-low interrupt pin.

Software uses a plain register port. Reads are combinational from `reg_addr`. Writes take effect on the rising clock edge where `reg_we` is high. Three addresses are mapped: status at 0, sticky at 1 and mask at 2. Every other address reads zero. In all three registers the four sources sit in bits 7 to 4. Bit 7 is init busy, bit 6 is PLL B unlocked, bit 5 is PLL A unlocked and bit 4 is reference lost.

A two-state machine drives the pin. In state IRQ_QUIET, `irq_n` is 1. The transition RAISE moves it to IRQ_RAISED, where `irq_n` is 0, at the first clock edge that sees any sticky bit whose mask bit is 0. The transition DROP returns it to IRQ_QUIET at the first edge that sees no such bit. Because `irq_n` is decoded from the state register alone, the pin is glitch-free.

Top module: `irq_status_ctl`

## Requirements
- R1: After reset the sticky and mask registers read 0x00 and `irq_n` is 1.
- R2: A read of address 0 returns the live conditions in bits 7:4, where 1 means active. Bit 7 is init busy, bit 6 is PLL B unlocked, bit 5 is PLL A unlocked and bit 4 is reference lost. Bits 3:2 read 0 and bits 1:0 return parameter `REV_ID` (default 1), so with no condition active the read is 0x01.
- R3: A 0-to-1 change of a condition sets the sticky bit at the same position of address 1 on the next clock edge. The bit stays set after the condition returns to 0.
- R4: A write to address 1 clears each sticky bit whose data bit is 0 and leaves unchanged each bit whose data bit is 1.
- R5: If a clearing write and a new rising condition on the same bit fall on the same edge, the bit ends up set.
- R6: The mask register at address 2 stores write bits 7:4. Bits 3:0 of the mask and sticky registers read 0 whatever was written.
- R7: For an unmasked source, `irq_n` goes to 0 at the second clock edge after the rising condition: one edge to set the sticky bit, one to move the pin state. It returns to 1 at the edge after the last unmasked sticky bit clears.
- R8: A sticky bit whose mask bit is 1 does not pull `irq_n` low. Writing 0 to that mask bit while the sticky bit is set drives `irq_n` low at the following edge.
- R9: Reads of unmapped addresses (3 to 15) return 0x00. Writes to address 0 or to unmapped addresses change no register.
- R10: A condition that stays at 1 does not set its sticky bit again once the bit has been cleared. Only a new 0-to-1 change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 4 | Live conditions: [3] init busy, [2] PLL B unlocked, [1] PLL A unlocked, [0] reference lost |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
A software write to the sticky register and a new rising condition on the same bit can land on the same clock edge. The two ask for opposite values, and the design must keep the bit set. The bench provokes this by raising the PLL B condition in the cycle where it writes 0x00 to address 1. It then reads address 1 back and expects 0x40, and checks that `irq_n` falls one edge later, as for any unmasked source.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int DATA_W  = 8;
    localparam int NSRC    = 4;
    localparam int SRC_LSB = DATA_W - NSRC;
    localparam int REV_W   = 2;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_STICKY = 1;
    localparam int ADDR_MASK   = 2;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clr,
    output logic flag
);
    logic cond_q;
    logic rise;

    assign rise = cond & ~cond_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            cond_q <= cond;
            if (rise)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_regmux.sv
module irq_regmux
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [REV_W-1:0] REV_ID = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [NSRC-1:0]   wsrc,
    input  logic [NSRC-1:0]   cond,
    input  logic [NSRC-1:0]   sticky,
    output logic [NSRC-1:0]   mask,
    output logic [DATA_W-1:0] rdata
);
    logic mask_wr;

    assign mask_wr = we && (addr == ADDR_W'(ADDR_MASK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_wr)
            mask <= wsrc;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_STATUS)) begin
            rdata[DATA_W-1:SRC_LSB] = cond;
            rdata[REV_W-1:0]        = REV_ID;
        end else if (addr == ADDR_W'(ADDR_STICKY)) begin
            rdata[DATA_W-1:SRC_LSB] = sticky;
        end else if (addr == ADDR_W'(ADDR_MASK)) begin
            rdata[DATA_W-1:SRC_LSB] = mask;
        end
    end
endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_n
);
    irq_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= IRQ_QUIET;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_QUIET:  if (pending)  state_nx = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_nx = IRQ_QUIET;
            default:                  state_nx = IRQ_QUIET;
        endcase
    end

    always_comb begin
        unique case (state)
            IRQ_RAISED: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [REV_W-1:0] REV_ID = 2'd1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     cond_i,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_n
);
    logic [NSRC-1:0] sticky;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] wsrc;
    logic            sticky_wr;
    logic            pending;
    logic            unused_wdata_lo;

    assign wsrc            = reg_wdata[DATA_W-1:SRC_LSB];
    assign unused_wdata_lo = ^reg_wdata[SRC_LSB-1:0];
    assign sticky_wr       = reg_we && (reg_addr == ADDR_W'(ADDR_STICKY));

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        irq_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (cond_i[g]),
            .clr   (sticky_wr & ~wsrc[g]),
            .flag  (sticky[g])
        );
    end

    irq_regmux #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .we     (reg_we),
        .wsrc   (wsrc),
        .cond   (cond_i),
        .sticky (sticky),
        .mask   (mask),
        .rdata  (reg_rdata)
    );

    assign pending = |(sticky & ~mask);

    irq_pin_fsm u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [REV_W-1:0] REV_ID = 2'd1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NSRC-1:0]     cond_i,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_we,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                irq_n,
    input logic [NSRC-1:0]     sticky,
    input logic [NSRC-1:0]     mask
);
    logic [NSRC-1:0] prev_c;
    logic [NSRC-1:0] rise_v;
    logic            wr_stk;
    logic            wr_msk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_c <= '0;
        else        prev_c <= cond_i;
    end

    assign rise_v = cond_i & ~prev_c;
    assign wr_stk = reg_we && (reg_addr == ADDR_W'(ADDR_STICKY));
    assign wr_msk = reg_we && (reg_addr == ADDR_W'(ADDR_MASK));

    // R3 and R5: a rising condition always leaves its sticky bit set
    assert_sticky_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_v != '0) |=> ((sticky & $past(rise_v)) == $past(rise_v)));

    // R3 and R10: without a write or a rise, the sticky bits hold
    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stk && rise_v == '0) |=> $stable(sticky));

    // R4
    assert_sticky_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stk && rise_v == '0) |=> (sticky == $past(sticky & reg_wdata[DATA_W-1:SRC_LSB])));

    // R6
    assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_msk |=> (mask == $past(reg_wdata[DATA_W-1:SRC_LSB])));

    // R7 and R8
    assert_irq_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == !$past(|(sticky & ~mask))));

    // R2
    assert_status_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADDR_STATUS)) |-> (reg_rdata[SRC_LSB-1:0] == {2'b00, REV_ID}));

    // R9
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(ADDR_MASK)) |-> (reg_rdata == '0));
endmodule

bind irq_status_ctl irq_status_chk #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond_i),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .sticky    (sticky),
    .mask      (mask)
);

// File: tb/test_irq_status_ctl.sv
`timescale 1ns/1ps
module test_irq_status_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond_i = '0;
    logic [3:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_status_ctl i_irq_status_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_i),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] cond;
        logic       we;
        logic [3:0] waddr;
        logic [7:0] wdata;
        logic [3:0] raddr;
        logic [7:0] exp;
        logic       exp_irq_n;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  4'b0000, 1'b0, 4'h0, 8'h00, 4'h0, 8'h01, 1'b1}, // R2 idle status
        '{4'd3,  4'b1000, 1'b0, 4'h0, 8'h00, 4'h1, 8'h80, 1'b0}, // R3 init busy rises
        '{4'd3,  4'b0000, 1'b0, 4'h0, 8'h00, 4'h1, 8'h80, 1'b0}, // R3 stays after fall
        '{4'd4,  4'b0000, 1'b1, 4'h1, 8'h7F, 4'h1, 8'h00, 1'b1}, // R4 clear bit 7
        '{4'd3,  4'b0110, 1'b0, 4'h0, 8'h00, 4'h1, 8'h60, 1'b0}, // R3 two PLLs
        '{4'd10, 4'b0110, 1'b1, 4'h1, 8'hBF, 4'h1, 8'h20, 1'b0}, // R10 and R4
        '{4'd6,  4'b0110, 1'b1, 4'h2, 8'h2F, 4'h2, 8'h20, 1'b1}, // R6 mask bit 5
        '{4'd7,  4'b0111, 1'b0, 4'h0, 8'h00, 4'h1, 8'h30, 1'b0}, // R7 ref lost
        '{4'd4,  4'b0111, 1'b1, 4'h1, 8'h00, 4'h1, 8'h00, 1'b1}, // R4 clear all
        '{4'd9,  4'b0111, 1'b1, 4'h0, 8'hFF, 4'h0, 8'h71, 1'b1}, // R9 status ro
        '{4'd9,  4'b0000, 1'b1, 4'h3, 8'hFF, 4'h3, 8'h00, 1'b1}, // R9 unmapped
        '{4'd9,  4'b0000, 1'b0, 4'h0, 8'h00, 4'h2, 8'h20, 1'b1}, // R9 mask kept
        '{4'd8,  4'b0010, 1'b0, 4'h0, 8'h00, 4'h1, 8'h20, 1'b1}, // R8 masked
        '{4'd8,  4'b0010, 1'b1, 4'h2, 8'h00, 4'h2, 8'h00, 1'b0}, // R8 unmask
        '{4'd4,  4'b0000, 1'b1, 4'h1, 8'h00, 4'hF, 8'h00, 1'b1}  // R4 and R9
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk("R1 status after reset", 4'h0, 8'h01);
        read_chk("R1 sticky after reset", 4'h1, 8'h00);
        read_chk("R1 mask after reset", 4'h2, 8'h00);
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            cond_i = VECS[i].cond;
            reg_we = VECS[i].we;
            reg_addr = VECS[i].waddr;
            reg_wdata = VECS[i].wdata;
            @(negedge clk);
            reg_we = 1'b0;
            reg_addr = VECS[i].raddr;
            @(negedge clk);
            #1;
            checks++;
            if (reg_rdata !== VECS[i].exp) begin
                fails++;
                $display("FAIL R%0d vec %0d rdata actual=%02h expected=%02h",
                         VECS[i].req, i, reg_rdata, VECS[i].exp);
            end
            checks++;
            if (irq_n !== VECS[i].exp_irq_n) begin
                fails++;
                $display("FAIL R%0d vec %0d irq_n actual=%0b expected=%0b",
                         VECS[i].req, i, irq_n, VECS[i].exp_irq_n);
            end
        end

        // R5: the clearing write and the PLL B rise fall on the same edge
        cond_i = 4'b0100;
        reg_we = 1'b1;
        reg_addr = 4'h1;
        reg_wdata = 8'h00;
        @(negedge clk);
        reg_we = 1'b0;
        read_chk("R5 set beats clear", 4'h1, 8'h40);
        check("R7 irq_n one edge after rise", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        check("R7 irq_n two edges after rise", {7'd0, irq_n}, 8'h00);
        cond_i = 4'b0000;
        reg_we = 1'b1;
        reg_addr = 4'h1;
        reg_wdata = 8'h00;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
        check("R7 irq_n after clear", {7'd0, irq_n}, 8'h01);

        // R1: reset in the middle of operation
        cond_i = 4'b0001;
        reg_we = 1'b1;
        reg_addr = 4'h2;
        reg_wdata = 8'h80;
        @(negedge clk);
        reg_we = 1'b0;
        read_chk("R3 ref lost sets", 4'h1, 8'h10);
        @(negedge clk);
        check("R7 irq_n ref lost", {7'd0, irq_n}, 8'h00);
        rst_n = 1'b0;
        cond_i = 4'b0000;
        #1;
        read_chk("R1 sticky mid reset", 4'h1, 8'h00);
        read_chk("R1 mask mid reset", 4'h2, 8'h00);
        check("R1 irq_n mid reset", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk("R1 sticky after release", 4'h1, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule